// File: doc/BRIEF.md
# Single-Round DES Feistel Unit

This block performs one round of the Data Encryption Standard per invocation, in the way a processor instruction would. The caller keeps the 64-bit data block and the key state in its own registers, presents them together with a 4-bit round number and a direction flag, pulses `start`, and one clock later gets back the updated block and key state. It writes both back and calls the unit again. Sixteen calls with round numbers 0 through 15 encrypt or decrypt one 8-byte block.

On round 0 the unit takes the raw block and the raw 8-byte key. It applies the initial bit permutation to the block and the 56-bit key selection to the key; the selection drops the low bit of every key byte. Between rounds the block travels as {left half, right half} and the key as the 56-bit selected state {C, D}, right-aligned in the 64-bit key word. Round 15 skips the half swap and applies the final permutation, so its data output is the finished result.

Top module: `des_round_unit`

## Requirements
- R1: `done` is high in exactly the cycle after a cycle with `start` high, and low after any cycle with `start` low.
- R2: While `rst_n` is low, `dataOut`, `keyOut` and `done` are all zero.
- R3: In a cycle without `start`, `dataOut` and `keyOut` keep their values whatever the other inputs do.
- R4: On round 0 the block passes through the initial permutation and the key through the 56-bit selection. After every invocation `keyOut[55:0]` holds the rotated state {C in bits 55:28, D in bits 27:0} and `keyOut[63:56]` is zero.
- R5: In encrypt mode (`decrypt` low) both key halves rotate left before the subkey is taken: by one bit on rounds 0, 1, 8 and 15 and by two bits on the rest. After round 15 the key state is back to its unrotated selection.
- R6: In decrypt mode (`decrypt` high) both halves rotate right: by zero on round 0, one bit on rounds 1, 8 and 15, and two bits on the rest.
- R7: Data travels as {L in 63:32, R in 31:0}. Rounds 0 to 14 return {R, L xor f(R, subkey)}. Round 15 returns the final permutation of {L xor f(R, subkey), R}.
- R8: Sixteen encrypt invocations, each fed the previous outputs, produce the standard DES ciphertext of the block under the key.
- R9: Sixteen decrypt invocations under the same key turn that ciphertext back into the plaintext.
- R10: Bit 0 of every key byte (the parity bits) has no effect on any result.
- R11: On rounds 1 to 15, `keyIn[63:56]` has no effect on any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Perform one round with the current inputs |
| decrypt | input | 1 | 1 selects the decryption key schedule |
| roundIdx | input | 4 | Round number, 0 to 15 |
| dataIn | input | 64 | Raw block on round 0, {L,R} otherwise |
| keyIn | input | 64 | Raw key on round 0, key state in bits 55:0 otherwise |
| dataOut | output | 64 | Updated block, final result after round 15 |
| keyOut | output | 64 | Rotated key state, bits 63:56 zero |
| done | output | 1 | Outputs were updated in the previous edge |

## Verification
Every invocation exposes the full cipher state on `keyOut` and `dataOut` one clock after `start`. A wrong rotation amount or direction therefore shows on `keyOut` in the very round where it happens. A fault in the S-boxes, the expansion or the permutations shows in the same round's `dataOut`, and after the remaining rounds it spreads to roughly half the bits of the final block. The bench checks known per-round values for the first rounds and known final ciphertexts. It also checks that the key state is unrotated again after round 15, and that decryption undoes encryption.

// File: rtl/des_round_pkg.sv
package des_round_pkg;

  localparam int DATA_W     = 64;
  localparam int HALF_W     = DATA_W / 2;
  localparam int KEY_W      = 64;
  localparam int KSTATE_W   = 56;
  localparam int KHALF_W    = KSTATE_W / 2;
  localparam int SUBKEY_W   = 48;
  localparam int NUM_ROUNDS = 16;
  localparam int ROUND_W    = $clog2(NUM_ROUNDS);
  localparam int NUM_SBOX   = 8;
  localparam int SBOX_IN_W  = SUBKEY_W / NUM_SBOX;
  localparam int SBOX_OUT_W = HALF_W / NUM_SBOX;

  typedef struct packed {
    logic       capture;
    logic       applyIp;
    logic       applyFp;
    logic       selectKey;
    logic       swapHalves;
    logic       rotRight;
    logic [1:0] rotAmt;
  } ctrlStrobe_t;

  // Source bit (1 = most significant) for each output bit of the P stage.
  localparam int unsigned P_SRC [HALF_W] = '{
    16, 7, 20, 21, 29, 12, 28, 17,  1, 15, 23, 26,  5, 18, 31, 10,
     2, 8, 24, 14, 32, 27,  3,  9, 19, 13, 30,  6, 22, 11,  4, 25};

  // Source bit for each bit of the 56-bit key selection.
  localparam int unsigned KSEL_SRC [KSTATE_W] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};

  // Source bit for each bit of the 48-bit round subkey.
  localparam int unsigned SUBK_SRC [SUBKEY_W] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

  // Substitution boxes, 64 nibbles each, row-major with entry 0 in the top nibble.
  localparam logic [255:0] SBOX_TAB [NUM_SBOX] = '{
    256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
    256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
    256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
    256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
    256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
    256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
    256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
    256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B};

  // Initial permutation source bit for output position i (0-based from MSB).
  function automatic int ipSrc(input int i);
    int row;
    int col;
    int base;
    row  = i / 8;
    col  = i % 8;
    base = (row < 4) ? (58 + 2 * row) : (57 + 2 * (row - 4));
    return base - 8 * col;
  endfunction

  // Expansion source bit for output position i (0-based from MSB).
  function automatic int expandSrc(input int i);
    int s;
    s = 4 * (i / 6) + (i % 6);
    if (s == 0) return HALF_W;
    if (s == HALF_W + 1) return 1;
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] initialPerm(input logic [DATA_W-1:0] x);
    logic [DATA_W-1:0] y;
    for (int i = 0; i < DATA_W; i++) y[DATA_W-1-i] = x[DATA_W-ipSrc(i)];
    return y;
  endfunction

  function automatic logic [DATA_W-1:0] finalPerm(input logic [DATA_W-1:0] x);
    logic [DATA_W-1:0] y;
    for (int i = 0; i < DATA_W; i++) y[DATA_W-ipSrc(i)] = x[DATA_W-1-i];
    return y;
  endfunction

  function automatic logic [SUBKEY_W-1:0] expandHalf(input logic [HALF_W-1:0] r);
    logic [SUBKEY_W-1:0] y;
    for (int i = 0; i < SUBKEY_W; i++) y[SUBKEY_W-1-i] = r[HALF_W-expandSrc(i)];
    return y;
  endfunction

  function automatic logic [HALF_W-1:0] pPerm(input logic [HALF_W-1:0] x);
    logic [HALF_W-1:0] y;
    for (int i = 0; i < HALF_W; i++) y[HALF_W-1-i] = x[HALF_W-int'(P_SRC[i])];
    return y;
  endfunction

  function automatic logic [KSTATE_W-1:0] keySelect(input logic [KEY_W-1:0] k);
    logic [KSTATE_W-1:0] y;
    for (int i = 0; i < KSTATE_W; i++) y[KSTATE_W-1-i] = k[KEY_W-int'(KSEL_SRC[i])];
    return y;
  endfunction

  function automatic logic [SUBKEY_W-1:0] subkeySelect(input logic [KSTATE_W-1:0] s);
    logic [SUBKEY_W-1:0] y;
    for (int i = 0; i < SUBKEY_W; i++) y[SUBKEY_W-1-i] = s[KSTATE_W-int'(SUBK_SRC[i])];
    return y;
  endfunction

  function automatic logic [SBOX_OUT_W-1:0] sboxLookup(input int box,
                                                       input logic [SBOX_IN_W-1:0] x);
    logic [255:0] tab;
    int idx;
    tab = SBOX_TAB[box];
    idx = int'({x[5], x[0]}) * 16 + int'(x[4:1]);
    return tab[252 - 4 * idx +: 4];
  endfunction

  function automatic logic [KHALF_W-1:0] rotHalf(input logic [KHALF_W-1:0] v,
                                                 input logic [1:0] amt,
                                                 input logic right);
    case (amt)
      2'd1:    return right ? {v[0], v[KHALF_W-1:1]} : {v[KHALF_W-2:0], v[KHALF_W-1]};
      2'd2:    return right ? {v[1:0], v[KHALF_W-1:2]} : {v[KHALF_W-3:0], v[KHALF_W-1:KHALF_W-2]};
      default: return v;
    endcase
  endfunction

  // Rounds whose encrypt rotation is a single bit.
  function automatic logic isShortShift(input int r);
    return (r == 0) || (r == 1) || (r == 8) || (r == NUM_ROUNDS - 1);
  endfunction

endpackage

// File: rtl/des_round_ctrl.sv
module des_round_ctrl
  import des_round_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               decrypt,
  input  logic [ROUND_W-1:0] roundIdx,
  output ctrlStrobe_t        strobe,
  output logic               done
);

  logic firstRound;
  logic lastRound;
  int   roundNum;

  always_comb begin
    roundNum   = int'(roundIdx);
    firstRound = (roundNum == 0);
    lastRound  = (roundNum == NUM_ROUNDS - 1);

    strobe            = '0;
    strobe.capture    = start;
    strobe.applyIp    = firstRound;
    strobe.selectKey  = firstRound;
    strobe.applyFp    = lastRound;
    strobe.swapHalves = !lastRound;
    strobe.rotRight   = decrypt;

    if (decrypt) begin
      // Decrypt walks the encrypt schedule backwards, one round behind.
      if (firstRound)                             strobe.rotAmt = 2'd0;
      else if (isShortShift(NUM_ROUNDS - roundNum)) strobe.rotAmt = 2'd1;
      else                                        strobe.rotAmt = 2'd2;
    end else begin
      strobe.rotAmt = isShortShift(roundNum) ? 2'd1 : 2'd2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) done <= 1'b0;
    else        done <= start;
  end

  assert_done_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  assert_no_spurious_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

endmodule

// File: rtl/des_round_keysched.sv
module des_round_keysched
  import des_round_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlStrobe_t         strobe,
  input  logic [KEY_W-1:0]    keyIn,
  output logic [KSTATE_W-1:0] nextState,
  output logic [SUBKEY_W-1:0] subKey
);

  logic [KSTATE_W-1:0] baseState;
  logic [KHALF_W-1:0]  cBase;
  logic [KHALF_W-1:0]  dBase;
  logic [KHALF_W-1:0]  cRot;
  logic [KHALF_W-1:0]  dRot;
  logic [7:0]          unusedParityBits;

  always_comb begin
    for (int b = 0; b < 8; b++) unusedParityBits[b] = keyIn[8 * b];
  end

  always_comb begin
    baseState = strobe.selectKey ? keySelect(keyIn) : keyIn[KSTATE_W-1:0];
    cBase     = baseState[KSTATE_W-1:KHALF_W];
    dBase     = baseState[KHALF_W-1:0];
    cRot      = rotHalf(cBase, strobe.rotAmt, strobe.rotRight);
    dRot      = rotHalf(dBase, strobe.rotAmt, strobe.rotRight);
    nextState = {cRot, dRot};
    subKey    = subkeySelect(nextState);
  end

  // A rotation only moves bits: each half keeps its weight (R5, R6).
  assert_rot_keeps_weight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |-> ($countones(cRot) == $countones(cBase)) &&
                       ($countones(dRot) == $countones(dBase)));

endmodule

// File: rtl/des_round_feistel.sv
module des_round_feistel
  import des_round_pkg::*;
(
  input  logic [HALF_W-1:0]   rightHalf,
  input  logic [SUBKEY_W-1:0] subKey,
  output logic [HALF_W-1:0]   fOut
);

  logic [SUBKEY_W-1:0] mixed;
  logic [HALF_W-1:0]   subst;

  assign mixed = expandHalf(rightHalf) ^ subKey;

  for (genvar g = 0; g < NUM_SBOX; g++) begin : gSbox
    assign subst[HALF_W-1-SBOX_OUT_W*g -: SBOX_OUT_W] =
      sboxLookup(g, mixed[SUBKEY_W-1-SBOX_IN_W*g -: SBOX_IN_W]);
  end

  assign fOut = pPerm(subst);

endmodule

// File: rtl/des_round_datapath.sv
module des_round_datapath
  import des_round_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [KEY_W-1:0]  keyIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [KEY_W-1:0]  keyOut
);

  logic [DATA_W-1:0]   preBlock;
  logic [HALF_W-1:0]   leftHalf;
  logic [HALF_W-1:0]   rightHalf;
  logic [HALF_W-1:0]   fVal;
  logic [HALF_W-1:0]   newLeft;
  logic [DATA_W-1:0]   mixBlock;
  logic [DATA_W-1:0]   postBlock;
  logic [KSTATE_W-1:0] nextState;
  logic [SUBKEY_W-1:0] subKey;

  des_round_keysched u_keysched (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .keyIn     (keyIn),
    .nextState (nextState),
    .subKey    (subKey)
  );

  des_round_feistel u_feistel (
    .rightHalf (rightHalf),
    .subKey    (subKey),
    .fOut      (fVal)
  );

  always_comb begin
    preBlock  = strobe.applyIp ? initialPerm(dataIn) : dataIn;
    leftHalf  = preBlock[DATA_W-1:HALF_W];
    rightHalf = preBlock[HALF_W-1:0];
    newLeft   = leftHalf ^ fVal;
    mixBlock  = strobe.swapHalves ? {rightHalf, newLeft} : {newLeft, rightHalf};
    postBlock = strobe.applyFp ? finalPerm(mixBlock) : mixBlock;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dataOut <= '0;
      keyOut  <= '0;
    end else if (strobe.capture) begin
      dataOut <= postBlock;
      keyOut  <= {{(KEY_W-KSTATE_W){1'b0}}, nextState};
    end
  end

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.capture |=> $stable(dataOut) && $stable(keyOut));

  assert_key_top_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |=> (keyOut[KEY_W-1:KSTATE_W] == '0));

  assert_right_moves_left_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.capture && strobe.swapHalves && !strobe.applyFp) |=>
      (dataOut[DATA_W-1:HALF_W] == $past(rightHalf)));

endmodule

// File: rtl/des_round_unit.sv
module des_round_unit
  import des_round_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               decrypt,
  input  logic [ROUND_W-1:0] roundIdx,
  input  logic [DATA_W-1:0]  dataIn,
  input  logic [KEY_W-1:0]   keyIn,
  output logic [DATA_W-1:0]  dataOut,
  output logic [KEY_W-1:0]   keyOut,
  output logic               done
);

  ctrlStrobe_t strobe;

  des_round_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .decrypt  (decrypt),
    .roundIdx (roundIdx),
    .strobe   (strobe),
    .done     (done)
  );

  des_round_datapath u_datapath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .dataIn  (dataIn),
    .keyIn   (keyIn),
    .dataOut (dataOut),
    .keyOut  (keyOut)
  );

endmodule

// File: tb/des_round_unit_tb.sv
module des_round_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        decrypt = 1'b0;
  logic [3:0]  roundIdx = '0;
  logic [63:0] dataIn = '0;
  logic [63:0] keyIn = '0;
  logic [63:0] dataOut;
  logic [63:0] keyOut;
  logic        done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  typedef struct {
    bit          chkData;
    bit          chkKey;
    logic [63:0] expData;
    logic [63:0] expKey;
    string       tag;
  } expItem_t;

  expItem_t sbQ[$];

  localparam logic [63:0] KEY_A    = 64'h133457799BBCDFF1;
  localparam logic [63:0] KEY_A_P  = 64'h123556789ABDDEF0;
  localparam logic [63:0] PT_A     = 64'h0123456789ABCDEF;
  localparam logic [63:0] CT_A     = 64'h85E813540F0AB405;
  localparam logic [63:0] KSEL_A   = 64'h00F0CCAAF556678F;
  localparam logic [63:0] KEY_B    = 64'h0E329232EA6D0D73;
  localparam logic [63:0] PT_B     = 64'h8787878787878787;
  localparam logic [63:0] CT_ZERO  = 64'h8CA64DE9C1B123A7;

  always #2 clk = ~clk;

  des_round_unit u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .decrypt  (decrypt),
    .roundIdx (roundIdx),
    .dataIn   (dataIn),
    .keyIn    (keyIn),
    .dataOut  (dataOut),
    .keyOut   (keyOut),
    .done     (done)
  );

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per done pulse.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sbQ.size() == 0) begin
        check64("R1 done without pending round", 64'd1, 64'd0);
      end else begin
        expItem_t it;
        it = sbQ.pop_front();
        if (it.chkData) check64({it.tag, " data"}, dataOut, it.expData);
        if (it.chkKey)  check64({it.tag, " key"},  keyOut,  it.expKey);
      end
    end
  end

  // Driver: one invocation, outputs returned for chaining.
  task automatic doRound(input logic [63:0] d, input logic [63:0] k, input bit dec,
                         input int r, input bit ckD, input logic [63:0] eD,
                         input bit ckK, input logic [63:0] eK, input string tag,
                         output logic [63:0] oD, output logic [63:0] oK);
    expItem_t it;
    @(negedge clk);
    dataIn   = d;
    keyIn    = k;
    decrypt  = dec;
    roundIdx = r[3:0];
    start    = 1'b1;
    it.chkData = ckD;
    it.chkKey  = ckK;
    it.expData = eD;
    it.expKey  = eK;
    it.tag     = tag;
    sbQ.push_back(it);
    @(negedge clk);
    start = 1'b0;
    oD = dataOut;
    oK = keyOut;
  endtask

  // Sixteen chained rounds; optional junk in keyIn[63:56] on rounds 1..15.
  task automatic runBlock(input logic [63:0] key, input logic [63:0] blk, input bit dec,
                          input bit junkTop, input logic [63:0] expOut,
                          input bit ckKey, input logic [63:0] expKey, input string tag);
    logic [63:0] d;
    logic [63:0] k;
    d = blk;
    k = key;
    for (int r = 0; r < 16; r++) begin
      logic [63:0] kin;
      kin = (junkTop && r > 0) ? {8'hA5, k[55:0]} : k;
      doRound(d, kin, dec, r, r == 15, expOut, ckKey && r == 15, expKey, tag, d, k);
    end
  endtask

  initial begin
    logic [63:0] d;
    logic [63:0] k;

    repeat (4) @(negedge clk);
    check64("R2 reset dataOut", dataOut, 64'h0);
    check64("R2 reset keyOut", keyOut, 64'h0);
    check64("R2 reset done", {63'h0, done}, 64'h0);
    rst_n = 1'b1;

    // Round 0 encrypt: IP, key selection, one-bit left rotation, swap.
    doRound(PT_A, KEY_A, 1'b0, 0, 1'b1, 64'hF0AAF0AAEF4A6544,
            1'b1, 64'h00E19955FAACCF1E, "R4 R5 R7 round0", d, k);

    // Idle cycles with changed inputs: nothing moves, no done.
    dataIn = 64'hFFFF_0000_FFFF_0000;
    keyIn  = 64'h1234_5678_9ABC_DEF0;
    roundIdx = 4'd7;
    decrypt = 1'b1;
    @(negedge clk);
    check64("R1 done low when idle", {63'h0, done}, 64'h0);
    @(negedge clk);
    check64("R3 dataOut held", dataOut, 64'hF0AAF0AAEF4A6544);
    check64("R3 keyOut held", keyOut, 64'h00E19955FAACCF1E);

    // Round 1 (one-bit) and round 2 (two-bit) encrypt.
    doRound(d, k, 1'b0, 1, 1'b1, 64'hEF4A6544CC017709,
            1'b1, 64'h00C332ABF5599E3D, "R5 R7 round1", d, k);
    doRound(d, k, 1'b0, 2, 1'b1, 64'hCC017709A25C0BF4,
            1'b1, 64'h000CCAAFF56678F5, "R5 R7 round2", d, k);

    // Full encryption; key state returns to its unrotated selection.
    runBlock(KEY_A, PT_A, 1'b0, 1'b0, CT_A, 1'b1, KSEL_A, "R8 R5 encrypt A");

    // Decrypt schedule: no rotation on round 0, one bit right on round 1.
    doRound(CT_A, KEY_A, 1'b1, 0, 1'b0, 64'h0, 1'b1, KSEL_A, "R4 R6 dec round0", d, k);
    doRound(d, k, 1'b1, 1, 1'b0, 64'h0, 1'b1, 64'h00F866557AAB33C7, "R6 dec round1", d, k);

    runBlock(KEY_A, CT_A, 1'b1, 1'b0, PT_A, 1'b0, 64'h0, "R9 decrypt A");
    runBlock(KEY_A_P, PT_A, 1'b0, 1'b0, CT_A, 1'b0, 64'h0, "R10 parity-flipped key");
    runBlock(64'h0, 64'h0, 1'b0, 1'b0, CT_ZERO, 1'b0, 64'h0, "R8 encrypt zero");
    runBlock(64'h0, CT_ZERO, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0, "R9 decrypt zero");
    runBlock(KEY_B, PT_B, 1'b0, 1'b1, 64'h0, 1'b0, 64'h0, "R11 R8 encrypt B junk top");
    runBlock(KEY_B, 64'h0, 1'b1, 1'b1, PT_B, 1'b0, 64'h0, "R11 R9 decrypt B junk top");

    @(negedge clk);
    check64("R1 every round produced done", 64'(sbQ.size()), 64'd0);
    check64("R1 done low at end", {63'h0, done}, 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected<=20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule